// File: doc/BRIEF.md
# Legacy Interrupt Status and Enable Aggregator

This block gathers the four level-sensitive legacy interrupt lines of a host bridge (lines A, B, C and D) into a single 32-bit control and status word. Each line has a sticky pending flag and an enable bit. The block drives one registered interrupt request upward to the parent interrupt controller whenever any enabled line has a pending flag.

Software reads the word at any time. It acknowledges a pending line by writing a one to that line's status bit. It sets or clears enables with full-word or byte-lane writes. The same word also holds several mask fields for error interrupts, requester priority bits and a ready-wait value. These are plain storage that other logic may decode. Because the status bits share the word with ordinary read/write fields, a read-modify-write that puts zeros in the status field leaves all pending flags as they are.

Top module: `legacy_irq_agg`

## Requirements
- R1: After reset, `rdData` reads 0x00000000 and `irqOut` is low. All enables, status flags and stored fields are zero.
- R2: Status bits 31:28 hold the pending flags of lines D..A, with line A (`intLine[0]`) in bit 28. A flag becomes 1 at the first clock edge at which its line is high. It stays 1 after the line falls, until software clears it.
- R3: A write with byte lane 3 enabled clears every status flag whose data bit in 31:28 is 1. Flags whose data bit is 0 are unchanged. If the line is high at the edge of the clearing write, the flag stays 1.
- R4: Bits 25:22 are the line enables for lines D..A, with line A in bit 22. A 1 enables the line and a 0 masks it.
- R5: `irqOut` is registered. One clock edge after any line has both its flag and its enable set, `irqOut` is 1. One edge after no line has both, it is 0.
- R6: A pending line whose enable is 0 still shows its status bit but does not raise `irqOut`.
- R7: Bits 27:26, 21:16, 14:8 and 3:0 are read/write storage that returns the last value written to it.
- R8: Bits 15 and 7:4 always read 0, whatever is written to them.
- R9: `wrByteEn[k]` gates data bits 8k+7:8k. A write changes only the enabled lanes, and the status clear of R3 needs lane 3. A halfword write of 0xF000 to the upper half (`wrByteEn`=4'b1100, `wrData`=0xF0000000) clears all four flags and masks all four lines in one access.
- R10: A full-word write whose bits 31:28 are zero leaves every status flag unchanged while it updates the other fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intLine | input | 4 | Level interrupt lines, bit 0 = line A |
| wrEn | input | 1 | Register write strobe |
| wrByteEn | input | 4 | Byte-lane enables for the write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register value |
| irqOut | output | 1 | Registered cascaded interrupt request |

## Verification
Each line is first pulsed alone, so a swapped line index or a status bit that is not sticky shows up at once. All sixteen patterns of the four lines are then driven against varied enable masks, which separates the OR-of-enabled-pending output from an output that ignores the enables or looks at only one line. A clear write is issued both while the line is idle and while it is still high. Enables and stored fields are rewritten with status bits both zero and one, and with every byte-lane combination, including the upper-halfword clear-and-mask. These cases tell write-one-to-clear apart from plain read/write behaviour and show lane gating.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_LINES  = 4;
  localparam int DATA_W     = 32;
  localparam int LANE_W     = 8;
  localparam int LANES      = DATA_W / LANE_W;
  localparam int STATUS_LSB = 28;
  localparam int ENABLE_LSB = 22;
  localparam int CLR_LANE   = STATUS_LSB / LANE_W;
  // writable non-status bits: 27:16, 14:8, 3:0
  localparam logic [DATA_W-1:0] CFG_RW_MASK = 32'h0FFF_7F0F;

  typedef struct packed {
    logic [NUM_LINES-1:0] clrStatus;
    logic [LANES-1:0]     laneWe;
    logic [DATA_W-1:0]    wrWord;
  } wr_strobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              wrEn,
  input  logic [LANES-1:0]  wrByteEn,
  input  logic [DATA_W-1:0] wrData,
  output wr_strobe_t        strobe
);
  logic clrLaneHit;

  assign clrLaneHit = wrEn & wrByteEn[CLR_LANE];

  always_comb begin
    strobe.laneWe    = wrEn ? wrByteEn : '0;
    strobe.clrStatus = clrLaneHit ? wrData[STATUS_LSB +: NUM_LINES] : '0;
    strobe.wrWord    = wrData;
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] intLine,
  input  wr_strobe_t           strobe,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut
);
  logic [NUM_LINES-1:0] statusQ;
  logic [DATA_W-1:0]    cfgQ;
  logic [DATA_W-1:0]    cfgNext;
  logic [NUM_LINES-1:0] enable;
  logic                 irqQ;

  assign enable = cfgQ[ENABLE_LSB +: NUM_LINES];

  // byte-lane gated update of the plain storage fields
  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_comb begin
      if (strobe.laneWe[g])
        cfgNext[g*LANE_W +: LANE_W] = strobe.wrWord[g*LANE_W +: LANE_W]
                                      & CFG_RW_MASK[g*LANE_W +: LANE_W];
      else
        cfgNext[g*LANE_W +: LANE_W] = cfgQ[g*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else       cfgQ <= cfgNext;
  end

  // sticky pending flags, set has priority over clear
  for (genvar i = 0; i < NUM_LINES; i++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    statusQ[i] <= 1'b0;
      else if (intLine[i])          statusQ[i] <= 1'b1;
      else if (strobe.clrStatus[i]) statusQ[i] <= 1'b0;
    end

    assert_line_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      intLine[i] |=> statusQ[i]);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !strobe.clrStatus[i]) |=> statusQ[i]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrStatus[i] && !intLine[i]) |=> !statusQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |(statusQ & enable);
  end

  assign irqOut = irqQ;
  assign rdData = cfgQ | (DATA_W'(statusQ) << STATUS_LSB);

  assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusQ & enable)) |=> irqOut);
  assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(|(statusQ & enable)) |=> !irqOut);
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.laneWe == '0) |=> $stable(cfgQ));
  assert_zero_status_keeps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStatus == '0) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
endmodule

// File: rtl/legacy_irq_agg.sv
module legacy_irq_agg
  import irq_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  intLine,
  input  logic        wrEn,
  input  logic [3:0]  wrByteEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irqOut
);
  wr_strobe_t strobe;

  irq_agg_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrByteEn (wrByteEn),
    .wrData   (wrData),
    .strobe   (strobe)
  );

  irq_agg_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .intLine (intLine),
    .strobe  (strobe),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );
endmodule

// File: tb/legacy_irq_agg_bench.sv
module legacy_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  intLine = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrByteEn = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference state
  bit [3:0]  mStatus = '0;
  bit [31:0] mCfg = '0;
  bit        mIrq = 1'b0;

  always #2.5 clk = ~clk;

  legacy_irq_agg u_legacy_irq_agg (
    .clk(clk), .rstN(rstN), .intLine(intLine), .wrEn(wrEn),
    .wrByteEn(wrByteEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic bit [31:0] modelRead();
    return {mStatus, 28'h0} | mCfg;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (rdData !== modelRead() || irqOut !== mIrq) begin
      fails++;
      $display("FAIL %s: rdData=%08h irqOut=%0b expected rdData=%08h irqOut=%0b",
               tag, rdData, irqOut, modelRead(), mIrq);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit [3:0] lines, input bit we, input bit [3:0] be,
                      input bit [31:0] data, input string tag);
    bit [3:0] clr;
    bit [3:0] nextStatus;
    intLine = lines; wrEn = we; wrByteEn = be; wrData = data;
    @(posedge clk);
    mIrq = |(mStatus & mCfg[25:22]);
    clr = (we && be[3]) ? data[31:28] : 4'h0;
    nextStatus = 4'h0;
    for (int i = 0; i < 4; i++)
      nextStatus[i] = lines[i] ? 1'b1 : (clr[i] ? 1'b0 : mStatus[i]);
    mStatus = nextStatus;
    if (we)
      for (int b = 0; b < 4; b++)
        if (be[b]) mCfg[b*8 +: 8] = data[b*8 +: 8] & 8'(32'h0FFF_7F0F >> (b*8));
    @(negedge clk);
    intLine = '0; wrEn = 1'b0; wrByteEn = '0; wrData = '0;
    compare(tag);
  endtask

  task automatic idle(input bit [3:0] lines, input string tag);
    step(lines, 1'b0, 4'h0, 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R2: single pulses, sticky flags, enables still 0 so R6 output low
    for (int i = 0; i < 4; i++) begin
      idle(4'(1 << i), "R2 line pulse");
      idle(4'h0, "R6 masked pending keeps irq low");
    end
    // R10: enable all with zero status field, flags kept
    step(4'h0, 1'b1, 4'hF, 32'h03C0_0000, "R10 rmw with zero status");
    idle(4'h0, "R5 irq rises one edge later");
    idle(4'h0, "R5 irq held");
    // R3: clear line A only
    step(4'h0, 1'b1, 4'hF, 32'h13C0_0000, "R3 w1c line A");
    idle(4'h0, "R3 after clear");
    // R3: clear line B while still high
    step(4'h2, 1'b1, 4'hF, 32'h23C0_0000, "R3 clear while line high");
    idle(4'h0, "R3 flag stays set");
    // clear everything, irq must fall
    step(4'h0, 1'b1, 4'h8, 32'hF300_0000, "R3 clear all");
    idle(4'h0, "R5 irq falls");
    idle(4'h0, "R5 irq low");
    // R4: enable only line C (bit 24)
    step(4'h0, 1'b1, 4'hF, 32'h0100_0000, "R4 enable line C only");
    idle(4'h1, "R6 line A masked");
    idle(4'h0, "R6 irq low");
    idle(4'h4, "R4 line C raises");
    idle(4'h0, "R5 irq up");
    step(4'h0, 1'b1, 4'h8, 32'h5000_0000, "R3 clear A and C");
    idle(4'h0, "R5 irq down");
    // R7/R8: storage and reserved bits
    step(4'h0, 1'b1, 4'hF, 32'h0FFF_FFFF, "R7 write all ones");
    idle(4'h0, "R8 reserved read zero");
    step(4'h0, 1'b1, 4'hF, 32'h0A5A_A5A5, "R7 pattern");
    idle(4'h0, "R7 readback");
    // R9: byte lanes
    for (int be = 0; be < 16; be++) begin
      step(4'h0, 1'b1, 4'(be), 32'h0FFF_FFFF ^ (32'(be) * 32'h0111_1111), "R9 byte lane");
      idle(4'h0, "R9 lane readback");
    end
    step(4'hF, 1'b1, 4'h7, 32'hF3FF_FFFF, "R9 status clear needs lane 3");
    idle(4'h0, "R9 flags kept");
    step(4'h0, 1'b1, 4'hC, 32'hF000_0000, "R9 halfword clear and mask");
    idle(4'h0, "R9 after halfword");
    // R5/R6: all line patterns against varied enables
    for (int en = 0; en < 16; en += 5) begin
      step(4'h0, 1'b1, 4'hC, {4'hF, 2'b00, 4'(en), 6'h00, 16'h0}, "R4 set enables");
      for (int p = 0; p < 16; p++) begin
        idle(4'(p), "R5 pattern");
        idle(4'h0, "R5 pattern settle");
        step(4'h0, 1'b1, 4'h8, {4'(p), 28'h0}, "R3 pattern clear");
      end
    end
    idle(4'h0, "R5 final");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule